// File: doc/BRIEF.md
# Command-Sequenced Register Port

This block is the slave side of a microcontroller bus on which every register is reached in two steps. A write with the address bit high loads an 8-bit opcode. The accesses that follow with the address bit low carry that opcode's payload into a small register file, or out of it. The register file holds a mode byte, a device address byte, a two-byte DMA setup word, a two-byte scratch word and a read-only frame counter. The number of payload accesses, their direction and the byte lanes are all fixed by the opcode, so the host never sees an address map.

A bus-width strap selects one of two payload forms. With a wide bus, each payload access moves the whole register in one word, with its low byte on bits 7:0. With a narrow bus, a two-byte register moves as two accesses, low byte first.

Whenever the serial engine reports suspend, the port locks itself. The lock remains after the suspend ends and is released only by an explicit unlock opcode. A reset opcode puts the register file back to its power-up state, in the same way the reset pin does.

Top module: `cmd_reg_port`

## Requirements
- R1: After `rst_n` the mode, DMA setup and device address outputs hold their reset values (all zero by default), and no command is pending.
- R2: A write strobe with `bus_cmd`=1 loads `bus_wdata[7:0]` as the opcode. A read strobe with `bus_cmd`=1 returns 0xFFFF and changes nothing.
- R3: Opcode 0xB8 writes the mode byte and 0xB9 reads it. Opcode 0xB6 writes the device address byte and 0xB7 reads it. In that byte, bits 6:0 drive `dev_addr_o` and bit 7 drives `dev_addr_en_o`. A one-byte register reads back with bits 15:8 at zero.
- R4: With `wide_bus`=1, the DMA setup word (write 0xF0, read 0xF1) and the scratch word (write 0xB2, read 0xB3) each move in a single data access. The low byte travels on bits 7:0.
- R5: With `wide_bus`=0, a two-byte register moves in two data accesses, low byte first, on bits 7:0. A write takes effect only when the high byte arrives. A write left after its low byte leaves the register unchanged.
- R6: A data access with no valid pending command returns 0xFFFF on reads and changes no register. This covers: no opcode loaded, an unknown opcode, every payload byte already moved, or an access in the direction opposite to the opcode.
- R7: Opcode 0xB4 reads the frame counter, zero-extended to 16 bits. The value is captured when the opcode is loaded, so later changes on `frame_num` do not affect bytes still to be read.
- R8: While `suspend` is high, and afterwards until opcode 0xB0 is loaded with `suspend` low, data writes are ignored and data reads return 0xFFFF. An unlock loaded while `suspend` is high has no effect.
- R9: Opcode 0xF6 takes no payload. It returns every register to its reset value and clears the lock, exactly as `rst_n` does.
- R10: `bus_rvalid` is high for exactly one cycle, one cycle after each read strobe. `bus_rdata` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select, qualifies both strobes |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_cmd | input | 1 | Address bit: 1 = opcode phase, 0 = payload phase |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| bus_rvalid | output | 1 | Read data valid pulse |
| wide_bus | input | 1 | 1 = 16-bit payload, 0 = 8-bit payload |
| suspend | input | 1 | Suspend indication from the serial engine |
| frame_num | input | FRAME_W | Current frame number |
| mode_o | output | 8 | Mode byte |
| dma_cfg_o | output | 16 | DMA setup word |
| dev_addr_o | output | 7 | Device address |
| dev_addr_en_o | output | 1 | Device address enable |

## Verification
The bench targets the points where a command-then-data port usually fails:
- If an extra read after the last payload byte were not blocked, the exhausted byte counter would give a stale value back instead of 0xFFFF.
- If a narrow write committed its low byte at once, an abandoned write would corrupt the DMA word.
- A live frame read would return bytes taken from two different frame numbers.
- For the lock, the bench fires an unlock during suspend and checks that reads stay blocked after suspend drops. A lock that cleared on the falling edge of suspend would release too early and fail that check.
- The bench also issues the reset opcode while the port is locked. A design that left the lock set, or that left one register out of the reset, would return the wrong value on the next read.

// File: rtl/cport_pkg.sv
package cport_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_SCRATCH,
      SEL_FRAME,
      SEL_DEVADR,
      SEL_MODE,
      SEL_DMA
   } sel_e;

   typedef struct packed {
      sel_e       sel;
      logic       rd;
      logic [1:0] nbytes;
      logic       unlock;
      logic       rst;
   } op_info_t;

   localparam logic [7:0] OP_UNLOCK   = 8'hB0;
   localparam logic [7:0] OP_SCR_WR   = 8'hB2;
   localparam logic [7:0] OP_FRAME_RD = 8'hB4;
   localparam logic [7:0] OP_DEV_WR   = 8'hB6;
   localparam logic [7:0] OP_MODE_WR  = 8'hB8;
   localparam logic [7:0] OP_DMA_WR   = 8'hF0;
   localparam logic [7:0] OP_RESET    = 8'hF6;

   // Register-carrying opcodes come in pairs: even = write, odd = read.
   function automatic op_info_t decode_op(input logic [7:0] op);
      op_info_t i;
      i     = '0;
      i.sel = SEL_NONE;
      case (op)
         OP_UNLOCK:   i.unlock = 1'b1;
         OP_RESET:    i.rst    = 1'b1;
         OP_FRAME_RD: begin
            i.sel    = SEL_FRAME;
            i.rd     = 1'b1;
            i.nbytes = 2'd2;
         end
         default: begin
            case ({op[7:1], 1'b0})
               OP_SCR_WR:  begin i.sel = SEL_SCRATCH; i.nbytes = 2'd2; end
               OP_DEV_WR:  begin i.sel = SEL_DEVADR;  i.nbytes = 2'd1; end
               OP_MODE_WR: begin i.sel = SEL_MODE;    i.nbytes = 2'd1; end
               OP_DMA_WR:  begin i.sel = SEL_DMA;     i.nbytes = 2'd2; end
               default:    i.sel = SEL_NONE;
            endcase
            if (i.sel != SEL_NONE) i.rd = op[0];
         end
      endcase
      return i;
   endfunction

endpackage

// File: rtl/cport_lock.sv
module cport_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic suspend,
   input  logic unlock_p,
   input  logic reset_p,
   output logic locked
);
   logic lock_q;

   // Suspend wins over unlock; the lock persists until an explicit release.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   lock_q <= 1'b0;
      else if (suspend)             lock_q <= 1'b1;
      else if (unlock_p || reset_p) lock_q <= 1'b0;
   end

   assign locked = lock_q;

   AST_UNLOCK_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !unlock_p && !reset_p) |=> locked); // R8
endmodule

// File: rtl/cport_tracker.sv
module cport_tracker
   import cport_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_stb,
   input  logic       data_wr,
   input  logic       data_rd,
   input  logic [7:0] op,
   input  logic       wide,
   input  logic       locked,
   output sel_e       sel,
   output logic       byte_idx,
   output logic       wr_go,
   output logic       rd_go,
   output logic       unlock_p,
   output logic       reset_p,
   output logic       snap_p
);
   op_info_t   info;
   sel_e       sel_q;
   logic       rd_q;
   logic [1:0] left_q;
   logic       idx_q;
   logic       live;

   assign info     = decode_op(op);
   assign unlock_p = cmd_stb & info.unlock;
   assign reset_p  = cmd_stb & info.rst;
   assign snap_p   = cmd_stb & (info.sel == SEL_FRAME);

   assign live  = (sel_q != SEL_NONE) && (left_q != 2'd0) && !locked;
   assign wr_go = data_wr & live & ~rd_q;
   assign rd_go = data_rd & live & rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= SEL_NONE;
         rd_q   <= 1'b0;
         left_q <= 2'd0;
         idx_q  <= 1'b0;
      end else if (cmd_stb) begin
         sel_q  <= info.sel;
         rd_q   <= info.rd;
         left_q <= info.nbytes;
         idx_q  <= 1'b0;
      end else if (wr_go || rd_go) begin
         if (wide) begin
            left_q <= 2'd0;
         end else begin
            left_q <= 2'(left_q - 2'd1);
            idx_q  <= 1'b1;
         end
      end
   end

   assign sel      = sel_q;
   assign byte_idx = idx_q;

   AST_NO_GO_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && wide && !cmd_stb) |=> !(data_rd && rd_go)); // R6
endmodule

// File: rtl/cport_regs.sv
module cport_regs
   import cport_pkg::*;
#(
   parameter int          FRAME_W    = 11,
   parameter logic [7:0]  MODE_RST   = 8'h00,
   parameter logic [7:0]  DEV_RST    = 8'h00,
   parameter logic [15:0] DMA_RST    = 16'h0000,
   parameter logic [15:0] SCR_RST    = 16'h0000,
   parameter bit          FRAME_SNAP = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  sel_e               sel,
   input  logic               byte_idx,
   input  logic               wide,
   input  logic               wr_go,
   input  logic               rd_go,
   input  logic               rd_stb,
   input  logic               snap_p,
   input  logic               soft_rst,
   input  logic [15:0]        wdata,
   input  logic [FRAME_W-1:0] frame_in,
   output logic [7:0]         mode_o,
   output logic [7:0]         dev_o,
   output logic [15:0]        dma_o,
   output logic [15:0]        rdata,
   output logic               rvalid
);
   localparam int DW = 16;

   logic [7:0]         mode_q, dev_q, hold_q;
   logic [DW-1:0]      dma_q, scr_q;
   logic [FRAME_W-1:0] frame_val;
   logic [DW-1:0]      frame16, full, rnext;
   logic [7:0]         lane;

   generate
      if (FRAME_SNAP) begin : g_snap
         logic [FRAME_W-1:0] frame_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      frame_q <= '0;
            else if (snap_p) frame_q <= frame_in;
         end
         assign frame_val = frame_q;
      end else begin : g_live
         assign frame_val = frame_in;
      end
   endgenerate

   assign frame16 = DW'(frame_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RST;
         dev_q  <= DEV_RST;
         dma_q  <= DMA_RST;
         scr_q  <= SCR_RST;
         hold_q <= 8'h00;
      end else if (soft_rst) begin
         mode_q <= MODE_RST;
         dev_q  <= DEV_RST;
         dma_q  <= DMA_RST;
         scr_q  <= SCR_RST;
         hold_q <= 8'h00;
      end else if (wr_go) begin
         case (sel)
            SEL_MODE:   mode_q <= wdata[7:0];
            SEL_DEVADR: dev_q  <= wdata[7:0];
            SEL_DMA: begin
               if (wide)           dma_q  <= wdata;
               else if (!byte_idx) hold_q <= wdata[7:0];
               else                dma_q  <= {wdata[7:0], hold_q};
            end
            SEL_SCRATCH: begin
               if (wide)           scr_q  <= wdata;
               else if (!byte_idx) hold_q <= wdata[7:0];
               else                scr_q  <= {wdata[7:0], hold_q};
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_MODE:    full = {8'h00, mode_q};
         SEL_DEVADR:  full = {8'h00, dev_q};
         SEL_DMA:     full = dma_q;
         SEL_SCRATCH: full = scr_q;
         SEL_FRAME:   full = frame16;
         default:     full = 16'hFFFF;
      endcase
      lane = byte_idx ? full[15:8] : full[7:0];
      if (!rd_go)    rnext = 16'hFFFF;
      else if (wide) rnext = full;
      else           rnext = {8'h00, lane};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= 16'hFFFF;
      end else begin
         rvalid <= rd_stb;
         if (rd_stb) rdata <= rnext;
      end
   end

   assign mode_o = mode_q;
   assign dev_o  = dev_q;
   assign dma_o  = dma_q;

   AST_HALF_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && !wide && !byte_idx && !soft_rst) |=> ($stable(dma_q) && $stable(scr_q))); // R5
   AST_SOFT_RESET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (mode_q == MODE_RST && dev_q == DEV_RST && dma_q == DMA_RST && scr_q == SCR_RST)); // R9
endmodule

// File: rtl/cmd_reg_port.sv
module cmd_reg_port
   import cport_pkg::*;
#(
   parameter int          FRAME_W    = 11,
   parameter logic [7:0]  MODE_RST   = 8'h00,
   parameter logic [7:0]  DEV_RST    = 8'h00,
   parameter logic [15:0] DMA_RST    = 16'h0000,
   parameter logic [15:0] SCR_RST    = 16'h0000,
   parameter bit          FRAME_SNAP = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_cs,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic               bus_cmd,
   input  logic [15:0]        bus_wdata,
   output logic [15:0]        bus_rdata,
   output logic               bus_rvalid,
   input  logic               wide_bus,
   input  logic               suspend,
   input  logic [FRAME_W-1:0] frame_num,
   output logic [7:0]         mode_o,
   output logic [15:0]        dma_cfg_o,
   output logic [6:0]         dev_addr_o,
   output logic               dev_addr_en_o
);
   generate
      if (FRAME_W < 1 || FRAME_W > 16) begin : g_bad_frame_w
         $error("cmd_reg_port: FRAME_W must be within 1..16");
      end
   endgenerate

   logic       wr_stb, rd_stb, cmd_stb, data_wr, data_rd;
   logic       wr_go, rd_go, unlock_p, reset_p, snap_p, locked, byte_idx;
   logic [7:0] dev_byte;
   sel_e       sel;

   assign wr_stb  = bus_cs & bus_wr & ~bus_rd;
   assign rd_stb  = bus_cs & bus_rd & ~bus_wr;
   assign cmd_stb = wr_stb & bus_cmd;
   assign data_wr = wr_stb & ~bus_cmd;
   assign data_rd = rd_stb & ~bus_cmd;

   cport_tracker u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_stb  (cmd_stb),
      .data_wr  (data_wr),
      .data_rd  (data_rd),
      .op       (bus_wdata[7:0]),
      .wide     (wide_bus),
      .locked   (locked),
      .sel      (sel),
      .byte_idx (byte_idx),
      .wr_go    (wr_go),
      .rd_go    (rd_go),
      .unlock_p (unlock_p),
      .reset_p  (reset_p),
      .snap_p   (snap_p)
   );

   cport_lock u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .suspend  (suspend),
      .unlock_p (unlock_p),
      .reset_p  (reset_p),
      .locked   (locked)
   );

   cport_regs #(
      .FRAME_W    (FRAME_W),
      .MODE_RST   (MODE_RST),
      .DEV_RST    (DEV_RST),
      .DMA_RST    (DMA_RST),
      .SCR_RST    (SCR_RST),
      .FRAME_SNAP (FRAME_SNAP)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .byte_idx (byte_idx),
      .wide     (wide_bus),
      .wr_go    (wr_go),
      .rd_go    (rd_go),
      .rd_stb   (rd_stb),
      .snap_p   (snap_p),
      .soft_rst (reset_p),
      .wdata    (bus_wdata),
      .frame_in (frame_num),
      .mode_o   (mode_o),
      .dev_o    (dev_byte),
      .dma_o    (dma_cfg_o),
      .rdata    (bus_rdata),
      .rvalid   (bus_rvalid)
   );

   assign dev_addr_o    = dev_byte[6:0];
   assign dev_addr_en_o = dev_byte[7];

   AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> bus_rvalid); // R10
   AST_RVALID_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> !bus_rvalid); // R10
   AST_BAD_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !rd_go) |=> (bus_rdata == 16'hFFFF)); // R6
   AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !reset_p) |=> ($stable(mode_o) && $stable(dma_cfg_o) && $stable(dev_byte))); // R8
endmodule

// File: tb/sim_cmd_reg_port.sv
`timescale 1ns/1ps
module sim_cmd_reg_port;
   localparam int FW = 11;

   typedef struct {
      logic [15:0] exp;
      string       req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_cs = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_cmd = 1'b0;
   logic [15:0]   bus_wdata = 16'h0000;
   logic [15:0]   bus_rdata;
   logic          bus_rvalid;
   logic          wide_bus = 1'b1;
   logic          suspend = 1'b0;
   logic [FW-1:0] frame_num = '0;
   logic [7:0]    mode_o;
   logic [15:0]   dma_cfg_o;
   logic [6:0]    dev_addr_o;
   logic          dev_addr_en_o;

   int   n_tests = 0;
   int   n_fail  = 0;
   exp_t sb[$];

   always #4 clk = ~clk;

   cmd_reg_port #(.FRAME_W(FW)) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_cs        (bus_cs),
      .bus_wr        (bus_wr),
      .bus_rd        (bus_rd),
      .bus_cmd       (bus_cmd),
      .bus_wdata     (bus_wdata),
      .bus_rdata     (bus_rdata),
      .bus_rvalid    (bus_rvalid),
      .wide_bus      (wide_bus),
      .suspend       (suspend),
      .frame_num     (frame_num),
      .mode_o        (mode_o),
      .dma_cfg_o     (dma_cfg_o),
      .dev_addr_o    (dev_addr_o),
      .dev_addr_en_o (dev_addr_en_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input logic cmd, input logic w, input logic [15:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_cmd = cmd; bus_wr = w; bus_rd = ~w; bus_wdata = d;
      @(negedge clk);
      bus_cs = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic op(input logic [7:0] code);
      access(1'b1, 1'b1, {8'h00, code});
   endtask

   task automatic wr(input logic [15:0] d);
      access(1'b0, 1'b1, d);
   endtask

   // Driver side of the scoreboard: push the expected word, then strobe.
   task automatic rd(input logic [15:0] exp, input string req, input logic cmd = 1'b0);
      exp_t e;
      e.exp = exp; e.req = req;
      sb.push_back(e);
      access(cmd, 1'b0, 16'h0000);
      check("R10 rvalid high", {31'd0, bus_rvalid}, 32'd1);
      @(negedge clk);
      check("R10 rvalid single", {31'd0, bus_rvalid}, 32'd0);
   endtask

   // Monitor side of the scoreboard.
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (sb.size() == 0) begin
            n_tests++; n_fail++;
            $display("FAIL R10 unexpected rvalid actual=%0h expected=none", bus_rdata);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, {16'd0, bus_rdata}, {16'd0, e.exp});
         end
      end
   end

   task automatic pulse_suspend();
      @(negedge clk); suspend = 1'b1;
      repeat (2) @(negedge clk);
      suspend = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 mode", {24'd0, mode_o}, 32'h00);
      check("R1 dma", {16'd0, dma_cfg_o}, 32'h0000);
      check("R1 dev", {24'd0, dev_addr_en_o, dev_addr_o}, 32'h00);
      rd(16'hFFFF, "R1 no pending read");
      rd(16'hFFFF, "R2 opcode-phase read", 1'b1);

      // Wide bus: one-byte registers
      wide_bus = 1'b1;
      op(8'hB8); wr(16'h12A5);
      check("R3 mode write", {24'd0, mode_o}, 32'hA5);
      op(8'hB9); rd(16'h00A5, "R3 mode read");
      rd(16'hFFFF, "R6 exhausted read");
      op(8'hB6); wr(16'h0095);
      check("R3 dev addr", {25'd0, dev_addr_o}, 32'h15);
      check("R3 dev enable", {31'd0, dev_addr_en_o}, 32'd1);
      op(8'hB7); rd(16'h0095, "R3 dev read");

      // Wide bus: two-byte registers
      op(8'hF0); wr(16'hBEEF);
      check("R4 dma wide write", {16'd0, dma_cfg_o}, 32'hBEEF);
      op(8'hF1); rd(16'hBEEF, "R4 dma wide read");
      op(8'hB2); wr(16'h1234);
      op(8'hB3); rd(16'h1234, "R4 scratch wide read");

      // Invalid data phases
      op(8'hB9); wr(16'h0011);
      check("R6 wrong-direction write", {24'd0, mode_o}, 32'hA5);
      op(8'h55); rd(16'hFFFF, "R6 unknown opcode read");
      op(8'hB8); rd(16'hFFFF, "R6 read under write opcode");

      // Narrow bus
      wide_bus = 1'b0;
      op(8'hF0); wr(16'h0034);
      check("R5 low byte held", {16'd0, dma_cfg_o}, 32'hBEEF);
      wr(16'h0012);
      check("R5 commit on high", {16'd0, dma_cfg_o}, 32'h1234);
      op(8'hF1); rd(16'h0034, "R5 low first"); rd(16'h0012, "R5 high second");
      rd(16'hFFFF, "R6 narrow exhausted");
      op(8'hB2); wr(16'h00AB);
      op(8'hB3); rd(16'h0034, "R5 abandoned lo"); rd(16'h0012, "R5 abandoned hi");
      op(8'hB8); wr(16'h003C);
      check("R5 narrow mode write", {24'd0, mode_o}, 32'h3C);
      op(8'hB9); rd(16'h003C, "R5 narrow mode read");

      // Frame counter
      frame_num = 11'h123;
      op(8'hB4);
      frame_num = 11'h7FF;
      rd(16'h0023, "R7 frame lo"); rd(16'h0001, "R7 frame hi");
      wide_bus = 1'b1;
      op(8'hB4); rd(16'h07FF, "R7 frame wide");
      op(8'hB5); rd(16'hFFFF, "R6 odd frame code");

      // Suspend lock
      pulse_suspend();
      op(8'hB8); wr(16'h0077);
      check("R8 locked write", {24'd0, mode_o}, 32'h3C);
      op(8'hB9); rd(16'hFFFF, "R8 locked read");
      @(negedge clk); suspend = 1'b1;
      op(8'hB0);
      @(negedge clk); suspend = 1'b0;
      op(8'hB9); rd(16'hFFFF, "R8 unlock during suspend");
      op(8'hB0);
      op(8'hB9); rd(16'h003C, "R8 after unlock");

      // Reset opcode
      op(8'hB6); wr(16'h00C4);
      op(8'hF6);
      check("R9 mode reset", {24'd0, mode_o}, 32'h00);
      check("R9 dma reset", {16'd0, dma_cfg_o}, 32'h0000);
      check("R9 dev reset", {24'd0, dev_addr_en_o, dev_addr_o}, 32'h00);
      op(8'hB3); rd(16'h0000, "R9 scratch reset");
      op(8'hB8); wr(16'h0066);
      pulse_suspend();
      op(8'hF6);
      op(8'hB9); rd(16'h0000, "R9 reset clears lock");

      repeat (4) @(negedge clk);
      check("R10 scoreboard drained", sb.size(), 32'd0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule